// File: doc/BRIEF.md
# Multiplexed Peripheral Interrupt Vector Encoder

This block merges twenty event-capture interrupt sources onto one shared request line for the main interrupt controller. Each source owns an enable bit and a pending bit. The enable bits live in two mask registers and the pending bits live in two pending registers, and all four sit on a small synchronous register bus. A hardware event on a source sets its pending bit whether or not the source is enabled. Software clears pending bits by writing ones to them.

A read-only vector register gives the number of the highest-numbered source that is both pending and enabled. Software can use that number directly as a jump-table index. The read that returns the number also clears the pending bit of that same source. The shared request output stays high while any of the twenty pending bits is set, so the main controller keeps seeing the request until every multiplexed source has been serviced or cleared.

Top module: `ivec_mux_top`

## Requirements
- R1: After reset, both mask registers and both pending registers read 0, the vector register reads 0 and `irq_out` is 0.
- R2: A one-cycle pulse on `src_evt[i]` sets the pending bit of source i+1, whether that source is enabled or masked. A masked pending bit stays set until it is cleared.
- R3: The vector register reads the largest k in 1..20 for which source k is both pending and enabled. It reads 0 when no such source exists. A pending bit whose enable bit is 0 plays no part in the result.
- R4: A read of the vector register that returns k (k > 0) clears the pending bit of source k in the same clock edge. No other pending bit changes. The value returned and the bit cleared are always the same source.
- R5: A read of the vector register that returns 0 leaves every pending bit unchanged.
- R6: `irq_out` is 1 exactly when at least one of the twenty pending bits is set, masked or not. It changes on the same clock edge as the pending bits.
- R7: Writing to a pending register clears every bit written as 1 and leaves every bit written as 0 unchanged (write-1-to-clear).
- R8: When a hardware event and a clear hit the same pending bit on the same edge, the bit ends up set. The clear may come from a vector read or from a write-1-to-clear.
- R9: A write to the vector address changes no mask or pending bit.
- R10: Register layout. Address 0 holds the mask bits and address 2 holds the pending bits of sources 1..16, with source k at bit k-1. Address 1 holds the mask bits and address 3 holds the pending bits of sources 17..20, at bits 0..3. Bits 4..15 of addresses 1 and 3 read 0. Address 4 is the vector register, with the number in bits 4..0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | 20 | Event strobes, bit i for source i+1 |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, holds until the next read |
| irq_out | output | 1 | Shared pending request toward the main controller |

## Verification
Every result of this block is due exactly one rising edge after its stimulus. An event strobe applied for one cycle shows up in the pending bits and in `irq_out` at the next edge. Read data, and the clear caused by a vector read, appear on the edge that samples the read strobe. The bench therefore drives inputs on the falling edge and samples outputs on the following falling edge. For the R8 collision cases it raises the event strobe and the clearing access in the same cycle, so both land on the same edge.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    A_MASK_LO = 3'd0,
    A_MASK_HI = 3'd1,
    A_PEND_LO = 3'd2,
    A_PEND_HI = 3'd3,
    A_VEC     = 3'd4
  } ivec_addr_e;
endpackage

// File: rtl/ivec_mask_regs.sv
module ivec_mask_regs #(
  parameter int NUM_SRC = 20,
  parameter int REG_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [REG_W-1:0]   wdata,
  output logic [NUM_SRC-1:0] mask
);
  localparam int HI_W = NUM_SRC - REG_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
    end else begin
      if (wr_lo) mask[REG_W-1:0]       <= wdata;
      if (wr_hi) mask[NUM_SRC-1:REG_W] <= wdata[HI_W-1:0];
    end
  end
endmodule

// File: rtl/ivec_pend_bank.sv
module ivec_pend_bank #(
  parameter int NUM_SRC = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_q,
  output logic               any_q
);
  logic [NUM_SRC-1:0] pend_d;

  // a set on the same edge as a clear keeps the bit
  always_comb pend_d = (pend_q & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      any_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      any_q  <= |pend_d;
    end
  end
endmodule

// File: rtl/ivec_prio_enc.sv
module ivec_prio_enc #(
  parameter int NUM_SRC = 20,
  parameter int VEC_W   = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC-1:0] req,
  output logic [VEC_W-1:0]   vec
);
  // highest index wins, 0 = nothing requested
  always_comb begin
    vec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i]) vec = VEC_W'(i + 1);
    end
  end
endmodule

// File: rtl/ivec_mux_top.sv
module ivec_mux_top #(
  parameter int NUM_SRC = 20,
  parameter int REG_W   = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC-1:0]        src_evt,
  input  logic                      bus_en,
  input  logic                      bus_we,
  input  logic [ivec_pkg::ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]          bus_wdata,
  output logic [REG_W-1:0]          bus_rdata,
  output logic                      irq_out
);
  import ivec_pkg::*;

  localparam int HI_W  = NUM_SRC - REG_W;
  localparam int VEC_W = $clog2(NUM_SRC + 1);

  logic               wr_acc, rd_acc, rd_vec;
  logic [NUM_SRC-1:0] mask, pend_q, w1c, rd_clr, clr_all;
  logic [VEC_W-1:0]   vec_sel;
  logic [REG_W-1:0]   rd_mux;

  assign wr_acc = bus_en & bus_we;
  assign rd_acc = bus_en & ~bus_we;
  assign rd_vec = rd_acc && (bus_addr == A_VEC);

  ivec_mask_regs #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_mask (
    .clk   (clk),
    .rst   (rst),
    .wr_lo (wr_acc && (bus_addr == A_MASK_LO)),
    .wr_hi (wr_acc && (bus_addr == A_MASK_HI)),
    .wdata (bus_wdata),
    .mask  (mask)
  );

  always_comb begin
    w1c = '0;
    if (wr_acc && (bus_addr == A_PEND_LO)) w1c[REG_W-1:0]       = bus_wdata;
    if (wr_acc && (bus_addr == A_PEND_HI)) w1c[NUM_SRC-1:REG_W] = bus_wdata[HI_W-1:0];
  end

  ivec_prio_enc #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_enc (
    .req (pend_q & mask),
    .vec (vec_sel)
  );

  // clear exactly the source that the vector read returns
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      rd_clr[i] = rd_vec && (vec_sel == VEC_W'(i + 1));
    end
  end

  assign clr_all = w1c | rd_clr;

  ivec_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .set_i  (src_evt),
    .clr_i  (clr_all),
    .pend_q (pend_q),
    .any_q  (irq_out)
  );

  always_comb begin
    case (bus_addr)
      A_MASK_LO: rd_mux = mask[REG_W-1:0];
      A_MASK_HI: rd_mux = {{(REG_W-HI_W){1'b0}}, mask[NUM_SRC-1:REG_W]};
      A_PEND_LO: rd_mux = pend_q[REG_W-1:0];
      A_PEND_HI: rd_mux = {{(REG_W-HI_W){1'b0}}, pend_q[NUM_SRC-1:REG_W]};
      A_VEC:     rd_mux = REG_W'(vec_sel);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_acc) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/ivec_mux_sva.sv
module ivec_mux_sva #(
  parameter int NUM_SRC = 20,
  parameter int REG_W   = 16,
  parameter int VEC_W   = $clog2(NUM_SRC + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_evt,
  input logic               bus_en,
  input logic               bus_we,
  input logic [2:0]         bus_addr,
  input logic [REG_W-1:0]   bus_rdata,
  input logic               irq_out,
  input logic [NUM_SRC-1:0] pend,
  input logic [VEC_W-1:0]   vec_sel
);
  logic               rd_vec, rd_vec_q;
  logic [NUM_SRC-1:0] hit;

  assign rd_vec = bus_en && !bus_we && (bus_addr == 3'd4);

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) hit[i] = (vec_sel == VEC_W'(i + 1));
  end

  always_ff @(posedge clk) begin
    if (rst) rd_vec_q <= 1'b0;
    else     rd_vec_q <= rd_vec;
  end

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
    rd_vec_q |-> (bus_rdata <= REG_W'(NUM_SRC))); // R3

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    irq_out == (|pend)); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|src_evt) |=> ((pend & $past(src_evt)) == $past(src_evt))); // R8

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_vec && (|hit) && !(|(hit & src_evt))) |=> !(|(pend & $past(hit)))); // R4

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_vec && vec_sel == '0 && !bus_we && src_evt == '0) |=> (pend == $past(pend))); // R5
endmodule

bind ivec_mux_top ivec_mux_sva #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .src_evt   (src_evt),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .pend      (pend_q),
  .vec_sel   (vec_sel)
);

// File: tb/ivec_mux_top_tb.sv
module ivec_mux_top_tb;
  localparam int NS = 20;
  localparam int RW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] src_evt = '0;
  logic          bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [RW-1:0] bus_wdata = '0;
  logic [RW-1:0] bus_rdata;
  logic          irq_out;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  ivec_mux_top #(.NUM_SRC(NS), .REG_W(RW)) u_dut (
    .clk(clk), .rst(rst), .src_evt(src_evt), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [RW-1:0] d, input logic [NS-1:0] ev = '0);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; src_evt = ev;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; src_evt = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [RW-1:0] d, input logic [NS-1:0] ev = '0);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; src_evt = ev;
    @(negedge clk);
    d = bus_rdata;
    bus_en = 1'b0; src_evt = '0;
  endtask

  task automatic pulse(input logic [NS-1:0] ev);
    @(negedge clk);
    src_evt = ev;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic clear_all();
    wr(3'd2, 16'hFFFF);
    wr(3'd3, 16'hFFFF);
  endtask

  task automatic t_reset();
    logic [RW-1:0] d;
    chk("R1 irq", irq_out, 0);
    rd(3'd0, d); chk("R1 mask_lo", d, 0);
    rd(3'd1, d); chk("R1 mask_hi", d, 0);
    rd(3'd2, d); chk("R1 pend_lo", d, 0);
    rd(3'd3, d); chk("R1 pend_hi", d, 0);
    rd(3'd4, d); chk("R1 vec", d, 0);
  endtask

  task automatic t_set_layout();
    logic [RW-1:0] d;
    wr(3'd0, 16'h0000); wr(3'd1, 16'h0000);
    pulse(20'h80001);            // sources 1 and 20, both masked
    chk("R6 irq set by masked src", irq_out, 1);
    rd(3'd2, d); chk("R2 R10 pend_lo bit0", d, 16'h0001);
    rd(3'd3, d); chk("R2 R10 pend_hi bit3", d, 16'h0008);
    rd(3'd4, d); chk("R3 masked ignored", d, 0);
    wr(3'd1, 16'hFFFF);
    rd(3'd1, d); chk("R10 mask_hi upper zero", d, 16'h000F);
    wr(3'd0, 16'hA5C3);
    rd(3'd0, d); chk("R10 mask_lo readback", d, 16'hA5C3);
    clear_all();
  endtask

  task automatic t_priority();
    logic [RW-1:0] d;
    wr(3'd0, 16'hFFFF); wr(3'd1, 16'h000F);
    pulse(20'h10004);            // sources 3 and 17
    rd(3'd4, d); chk("R3 R4 highest 17", d, 17);
    rd(3'd3, d); chk("R4 src17 cleared", d, 0);
    rd(3'd2, d); chk("R4 src3 kept", d, 16'h0004);
    pulse(20'h80000);            // source 20, then mask it
    wr(3'd1, 16'h0007);
    rd(3'd4, d); chk("R3 masked 20 skipped", d, 3);
    chk("R6 irq holds, 20 still pending", irq_out, 1);
    rd(3'd3, d); chk("R2 masked 20 latched", d, 16'h0008);
    wr(3'd3, 16'h0008);
    chk("R6 irq low when all clear", irq_out, 0);
  endtask

  task automatic t_empty_read();
    logic [RW-1:0] d;
    wr(3'd0, 16'h0000); wr(3'd1, 16'h0000);
    pulse(20'h00030);
    rd(3'd4, d); chk("R5 empty vec", d, 0);
    rd(3'd2, d); chk("R5 pend untouched", d, 16'h0030);
    clear_all();
  endtask

  task automatic t_w1c();
    logic [RW-1:0] d;
    pulse(20'h3F00F);
    wr(3'd2, 16'h0005);
    rd(3'd2, d); chk("R7 w1c lo", d, 16'hF00A);
    wr(3'd3, 16'h0002);
    rd(3'd3, d); chk("R7 w1c hi", d, 16'h0001);
    clear_all();
    chk("R7 irq after clear", irq_out, 0);
  endtask

  task automatic t_set_wins();
    logic [RW-1:0] d;
    wr(3'd0, 16'hFFFF); wr(3'd1, 16'h000F);
    pulse(20'h80000);
    rd(3'd4, d, 20'h80000); chk("R8 vec read with event", d, 20);
    rd(3'd3, d); chk("R8 read-clear loses", d, 16'h0008);
    wr(3'd2, 16'h0001, 20'h00001);
    rd(3'd2, d); chk("R8 w1c loses", d, 16'h0001);
    clear_all();
  endtask

  task automatic t_vec_write();
    logic [RW-1:0] d;
    wr(3'd0, 16'h0100); wr(3'd1, 16'h0000);
    pulse(20'h00100);
    wr(3'd4, 16'hFFFF);
    rd(3'd2, d); chk("R9 pend kept", d, 16'h0100);
    rd(3'd0, d); chk("R9 mask kept", d, 16'h0100);
    rd(3'd4, d); chk("R9 vec 9", d, 9);
    chk("R6 R4 irq drops on last read-clear", irq_out, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_set_layout();
    t_priority();
    t_empty_read();
    t_w1c();
    t_set_wins();
    t_vec_write();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule